// File: doc/BRIEF.md
# Wormhole Router Input Port with Lookahead Routing

This block is one input port of a five-port wormhole router in a two-dimensional mesh. Flits arrive from the upstream router and wait in a small FIFO. The port raises a request to the switch allocator on the output that the flit at the head of the FIFO names. The upstream router already chose that output and wrote it into the flit as a one-hot field. When the allocator grants the port, the head flit moves into a pipeline register that drives the crossbar in the following cycle. As the flit moves, the port computes the output that the *next* router must use and writes it into the flit in place of the old field. Each hop therefore gets its routing one router ahead of time, and no route computation sits in a router's critical stage.

Flow control toward the upstream router is stop-go. A stop line rises as soon as the FIFO holds two or more flits, which leaves room for a flit already in flight while the stop travels upstream. Packets are kept whole on their output. Once a non-tail flit of a packet has been granted, the port keeps requesting that same output, even while its FIFO is briefly empty. It releases the output only when the tail flit is granted. The router's own mesh coordinates and the mesh size are parameters.

Top module: `wh_la_port`

## Requirements
- R1: A flit is 74 bits. Bits [63:0] are payload. Bits [68:64] are a one-hot output port, with bit 0 for local, bit 1 for east (+x), bit 2 for west (-x), bit 3 for north (+y) and bit 4 for south (-y). Bits [70:69] are the destination x, bits [72:71] the destination y, and bit 73 marks the tail. Payload, destination and tail bits leave the port unchanged.
- R2: The FIFO holds up to 4 flits and delivers them in arrival order.
- R3: An arriving flit is dropped when the FIFO holds 4 flits and no flit leaves in that cycle. When a flit leaves in the same cycle, the arriving flit is accepted.
- R4: `up_stop` is high exactly when the FIFO holds 2 or more flits.
- R5: While no packet holds an output, `sa_req` equals the port field of the head flit, or zero when the FIFO is empty.
- R6: After a non-tail flit is granted, `sa_req` stays at that flit's port until a tail flit is granted, including cycles in which the FIFO is empty.
- R7: A grant while the FIFO is non-empty removes the head flit and sets `xb_valid` for exactly the next cycle, with that flit on `xb_flit`. A grant while the FIFO is empty has no effect.
- R8: The outgoing port field is computed X first. The port steps its own coordinates one hop in the direction of the current port field to get the next router's position. It then selects east or west if the destination x differs from that position, else north or south if the destination y differs, else local.
- R9: A flit whose current port field is local leaves with the port field set to local.
- R10: After a synchronous active-low reset, `up_stop`, `sa_req` and `xb_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | A flit is offered on `up_flit` this cycle |
| up_flit | input | 74 | Incoming flit |
| up_stop | output | 1 | Tells the upstream router to stop sending |
| sa_req | output | 5 | One-hot output request to the switch allocator |
| sa_grant | input | 1 | Allocator grant for this port |
| xb_valid | output | 1 | The pipeline register holds a flit for the crossbar |
| xb_flit | output | 74 | Flit toward the crossbar, with the port field for the next router |

## Verification
The bench targets several failure modes:
- Overflow. A design that let a fifth flit in would overwrite the oldest entry, and the drained order would show it.
- Push and pop in the same cycle while full. A design that dropped the arriving flit would lose it.
- Lock release. A design that released its request between the flits of a packet would show `sa_req` falling to zero while the FIFO is empty mid-packet.
- Grant on an empty FIFO. Such a grant must not produce a spurious `xb_valid`.
- Routing. The new port field is checked against a bench model over random destinations and every current direction. This exposes a Y-before-X order, an off-by-one in the neighbour step, and a wrong result for flits that are leaving to the local tile.

// File: rtl/wh_la_pkg.sv
// Package: shared port numbering for the lookahead input port.
// Assumes a five-port mesh router; the one-hot port fields use these bit indices.
package wh_la_pkg;
    localparam int NPORT   = 5;
    localparam int P_LOCAL = 0;
    localparam int P_EAST  = 1;
    localparam int P_WEST  = 2;
    localparam int P_NORTH = 3;
    localparam int P_SOUTH = 4;
endpackage

// File: rtl/wh_la_fifo.sv
// Module: flit FIFO with a stop-go threshold output.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// A push is accepted when there is room, or when a pop frees an entry in the same cycle.
module wh_la_fifo #(
    parameter int W        = 74,
    parameter int DEPTH    = 4,
    parameter int NF_LEVEL = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         stop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, push_ok, pop_ok;

    // Accept/remove qualification.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        head    = mem[rd_ptr];
        stop    = (count >= CW'(NF_LEVEL));
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy never exceeds the depth.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R4: stop can only rise after a flit was accepted.
    a_r4_stop_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |-> $past(push_ok));
endmodule

// File: rtl/wh_la_route.sv
// Module: lookahead route computation, dimension ordered (X first).
// Steps the router's own position one hop along cur_port to find the next router,
// then picks that router's output for the destination. Local or empty cur_port gives local.
module wh_la_route
    import wh_la_pkg::*;
#(
    parameter int XW   = 2,
    parameter int YW   = 2,
    parameter int MY_X = 1,
    parameter int MY_Y = 2
) (
    input  logic [NPORT-1:0] cur_port,
    input  logic [XW-1:0]    dst_x,
    input  logic [YW-1:0]    dst_y,
    output logic [NPORT-1:0] nxt_port
);
    logic [XW:0] nx, dx;
    logic [YW:0] ny, dy;

    // Next-router position and X-then-Y comparison.
    always_comb begin
        nx = (XW+1)'(MY_X);
        ny = (YW+1)'(MY_Y);
        dx = {1'b0, dst_x};
        dy = {1'b0, dst_y};
        if (cur_port[P_EAST])  nx = nx + (XW+1)'(1);
        if (cur_port[P_WEST])  nx = nx - (XW+1)'(1);
        if (cur_port[P_NORTH]) ny = ny + (YW+1)'(1);
        if (cur_port[P_SOUTH]) ny = ny - (YW+1)'(1);
        nxt_port = '0;
        if (cur_port[P_LOCAL] || cur_port == '0) nxt_port[P_LOCAL] = 1'b1;
        else if (dx > nx)                        nxt_port[P_EAST]  = 1'b1;
        else if (dx < nx)                        nxt_port[P_WEST]  = 1'b1;
        else if (dy > ny)                        nxt_port[P_NORTH] = 1'b1;
        else if (dy < ny)                        nxt_port[P_SOUTH] = 1'b1;
        else                                     nxt_port[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/wh_la_req.sv
// Module: switch request generation with a per-packet output lock.
// Assumes every flit of a packet names the same output; the lock is held from a
// granted non-tail flit until the granted tail flit.
module wh_la_req
    import wh_la_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             empty,
    input  logic [NPORT-1:0] head_port,
    input  logic             head_tail,
    input  logic             pop,
    output logic [NPORT-1:0] req
);
    logic             lock_q;
    logic [NPORT-1:0] lport_q;

    // Request: locked output first, else the head flit's port.
    always_comb begin
        if (lock_q)      req = lport_q;
        else if (!empty) req = head_port;
        else             req = '0;
    end

    // Lock tracking across the flits of a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            lport_q <= '0;
        end else if (pop) begin
            lock_q  <= !head_tail;
            lport_q <= head_port;
        end
    end

    // R5: at most one output requested.
    a_r5_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));
    // R6: request stays put while a packet holds its output.
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !pop) |=> $stable(req));
endmodule

// File: rtl/wh_la_port.sv
// Module: wormhole router input port with lookahead routing and stop-go flow control.
// Buffers flits, requests the output named in the head flit, and on grant loads the head
// into the crossbar pipeline register with its port field rewritten for the next router.
// Assumes the allocator grants only while sa_req is non-zero.
module wh_la_port
    import wh_la_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int DEPTH    = 4,
    parameter int NF_LEVEL = 2,
    parameter int MESH_X   = 4,
    parameter int MESH_Y   = 4,
    parameter int MY_X     = 1,
    parameter int MY_Y     = 2,
    localparam int XW      = $clog2(MESH_X),
    localparam int YW      = $clog2(MESH_Y),
    localparam int FLIT_W  = DATA_W + NPORT + XW + YW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic [FLIT_W-1:0] up_flit,
    output logic              up_stop,
    output logic [NPORT-1:0]  sa_req,
    input  logic              sa_grant,
    output logic              xb_valid,
    output logic [FLIT_W-1:0] xb_flit
);
    localparam int PORT_LSB = DATA_W;
    localparam int X_LSB    = PORT_LSB + NPORT;
    localparam int Y_LSB    = X_LSB + XW;
    localparam int TAIL_B   = Y_LSB + YW;

    logic [FLIT_W-1:0] head;
    logic              empty, pop;
    logic [NPORT-1:0]  head_port, la_port;

    // Grant qualified by a non-empty FIFO.
    always_comb begin
        pop       = sa_grant && !empty;
        head_port = head[X_LSB-1:PORT_LSB];
    end

    wh_la_fifo #(.W(FLIT_W), .DEPTH(DEPTH), .NF_LEVEL(NF_LEVEL)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(up_valid), .din(up_flit),
        .pop(pop), .head(head), .empty(empty), .stop(up_stop)
    );

    wh_la_route #(.XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .cur_port(head_port), .dst_x(head[Y_LSB-1:X_LSB]),
        .dst_y(head[TAIL_B-1:Y_LSB]), .nxt_port(la_port)
    );

    wh_la_req u_req (
        .clk(clk), .rst_n(rst_n), .empty(empty), .head_port(head_port),
        .head_tail(head[TAIL_B]), .pop(pop), .req(sa_req)
    );

    // Crossbar pipeline register, loaded on a qualified grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xb_valid <= 1'b0;
            xb_flit  <= '0;
        end else begin
            xb_valid <= pop;
            if (pop) xb_flit <= {head[FLIT_W-1:X_LSB], la_port, head[DATA_W-1:0]};
        end
    end

    // R7: the pipeline register only fills after a grant.
    a_r7_pipe_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid |-> $past(sa_grant));
    // R8: the rewritten port field names exactly one output.
    a_r8_next_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        xb_valid |-> ($countones(xb_flit[X_LSB-1:PORT_LSB]) == 1));
endmodule

// File: tb/wh_la_port_tb.sv
module wh_la_port_tb;
    localparam int FW = 74;
    localparam int MYX = 1;
    localparam int MYY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_valid = 1'b0;
    logic [FW-1:0] up_flit = '0;
    logic          up_stop;
    logic [4:0]    sa_req;
    logic          sa_grant = 1'b0;
    logic          xb_valid;
    logic [FW-1:0] xb_flit;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [FW-1:0] mq[$];
    bit            locked = 0;
    logic [4:0]    lport = '0;
    bit            exp_xv = 0;
    logic [FW-1:0] exp_xf = '0;

    wh_la_port u_dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_flit(up_flit),
        .up_stop(up_stop), .sa_req(sa_req), .sa_grant(sa_grant),
        .xb_valid(xb_valid), .xb_flit(xb_flit)
    );

    always #4 clk = ~clk;

    function automatic logic [4:0] look(input logic [4:0] p, input int dx, input int dy);
        int nx = MYX;
        int ny = MYY;
        if (p == 5'b00001) return 5'b00001;
        if (p == 5'b00010) nx = nx + 1;
        if (p == 5'b00100) nx = nx - 1;
        if (p == 5'b01000) ny = ny + 1;
        if (p == 5'b10000) ny = ny - 1;
        if (dx > nx) return 5'b00010;
        if (dx < nx) return 5'b00100;
        if (dy > ny) return 5'b01000;
        if (dy < ny) return 5'b10000;
        return 5'b00001;
    endfunction

    function automatic logic [FW-1:0] mk(input logic [4:0] p, input int dx, input int dy,
                                         input bit tl, input logic [63:0] d);
        return {tl, 2'(dy), 2'(dx), p, d};
    endfunction

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", rq, cyc, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [4:0] er;
        er = locked ? lport : (mq.size() > 0 ? mq[0][68:64] : 5'b0);
        chk((locked && mq.size() == 0) ? "R6" : "R5", 128'(sa_req), 128'(er));
        chk("R4", 128'(up_stop), 128'(mq.size() >= 2));
        chk("R7", 128'(xb_valid), 128'(exp_xv));
        if (exp_xv && xb_valid) begin
            chk("R1", 128'({xb_flit[73:69], xb_flit[63:0]}), 128'({exp_xf[73:69], exp_xf[63:0]}));
            chk(exp_xf[68:64] == 5'b00001 ? "R9" : "R8", 128'(xb_flit[68:64]), 128'(exp_xf[68:64]));
        end
    endtask

    // Drive one cycle, advance the model, then check at the next falling edge.
    task automatic step(input bit v, input logic [FW-1:0] f, input bit g);
        bit pop, pu;
        logic [FW-1:0] h;
        up_valid = v; up_flit = f; sa_grant = g;
        pop = g && mq.size() > 0;
        pu = v && (mq.size() < 4 || pop);
        exp_xv = pop;
        if (pop) begin
            h = mq.pop_front();
            exp_xf = {h[73:69], look(h[68:64], int'(h[70:69]), int'(h[72:71])), h[63:0]};
            locked = !h[73];
            lport = h[68:64];
        end
        if (pu) mq.push_back(f);
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int plen;
        logic [4:0] pp;
        int pdx, pdy;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", 128'({up_stop, sa_req, xb_valid}), 128'(0));

        // R3/R2: overflow while not draining, then drain in order
        for (int i = 0; i < 6; i++)
            step(1, mk(5'b00010, 3, i % 4, 1, 64'(i) + 64'hA000), 0);
        for (int i = 0; i < 6; i++) step(0, '0, 1);
        // R3: full FIFO with a simultaneous pop accepts the new flit
        for (int i = 0; i < 4; i++) step(1, mk(5'b01000, 1, 3, 1, 64'(i)), 0);
        step(1, mk(5'b10000, 0, 0, 1, 64'hBEEF), 1);
        for (int i = 0; i < 5; i++) step(0, '0, 1);

        // R9: flit leaving to the local tile; R8 edge: destination at the next router
        step(1, mk(5'b00001, 2, 1, 1, 64'h1), 0);
        step(0, '0, 1);
        step(1, mk(5'b00010, 2, 2, 1, 64'h2), 0);
        step(0, '0, 1);
        step(0, '0, 0);

        // R6/R7: lock held across an empty FIFO; grant while empty ignored
        step(1, mk(5'b00100, 0, 3, 0, 64'h10), 0);
        step(0, '0, 1);
        step(0, '0, 0);
        step(0, '0, 1);
        step(1, mk(5'b00100, 0, 3, 1, 64'h11), 0);
        step(0, '0, 1);
        step(0, '0, 0);

        // Random packets with an upstream that honours stop
        plen = 0; pp = 5'b00001; pdx = 0; pdy = 0;
        for (int i = 0; i < 4000; i++) begin
            bit v, g;
            logic [FW-1:0] f;
            v = !up_stop && ($urandom_range(0, 99) < 60);
            g = (sa_req != 0) && ($urandom_range(0, 99) < 50);
            f = '0;
            if (v) begin
                if (plen == 0) begin
                    plen = $urandom_range(1, 4);
                    pp = 5'(1 << $urandom_range(0, 4));
                    pdx = $urandom_range(0, 3);
                    pdy = $urandom_range(0, 3);
                end
                f = mk(pp, pdx, pdy, plen == 1, {$urandom, $urandom});
                plen--;
            end
            step(v, f, g);
        end
        for (int i = 0; i < 8; i++) step(0, '0, (sa_req != 0));

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule